// File: doc/BRIEF.md
# Lane-Pair Serial Link Reset Sequencer

This block brings up a serial link built from four lanes grouped into two lane pairs. A start request forces every lane power-down, every lane reset and every pair PLL reset active in the same cycle. The block then releases those controls one group at a time. Each group is released a fixed settle time after the one before it. Within a pair, power-down clears first, then the shared PLL reset, then the lane resets. The first pair finishes before the second pair begins. A status output stays high while a sequence runs, and a single-cycle done pulse marks the end of the sequence.

A second, independent request produces one active-low pulse of fixed width on the coding-sublayer reset line. A per-lane configuration word goes out beside the control bits. It is registered once and is otherwise untouched. All wait lengths are given in microseconds and scaled by a clock-frequency parameter in MHz. The number of lane pairs is a parameter, with two lanes per pair.

Top module: `serdes_rst_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, every bit of `pwrdn`, `pll_rst` and `lane_rst` is 1, `pcs_rst_n` is 1, and `busy` and `done` are 0.
- R2: A `start` sampled high while `busy` is 0 makes `busy` 1 and sets every bit of `pwrdn`, `pll_rst` and `lane_rst` to 1 after that same clock edge.
- R3: The first group clears exactly WAIT_CYC = CLK_MHZ*WAIT_US cycles after the start edge. Each later group clears exactly WAIT_CYC cycles after the previous one. No control changes in between.
- R4: Each release clears exactly one group, in this order for pair p = 0, 1, ...: `pwrdn[2p+1:2p]`, then `pll_rst[p]`, then `lane_rst[2p+1:2p]`. Lane i is bit i, and pair p is bit p of `pll_rst`. No control bit is set again while a sequence runs.
- R5: One cycle after the last group clears, `busy` falls and `done` is 1 for exactly one cycle.
- R6: A `start` sampled while `busy` is 1 is ignored. The release timing and the control values are unchanged.
- R7: A `pcs_start` sampled while `pcs_rst_n` is 1 drives `pcs_rst_n` to 0 for exactly PCS_CYC = CLK_MHZ*PCS_US cycles. After that it returns to 1.
- R8: A `pcs_start` sampled while `pcs_rst_n` is 0 is ignored. The pulse neither lengthens nor repeats.
- R9: `cfg_out` equals the value of `cfg_in` one clock earlier, in every cycle including during a sequence. Lane i owns bits [CFG_W*i +: CFG_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a full release sequence |
| pcs_start | input | 1 | Request a coding-sublayer reset pulse |
| cfg_in | input | 2*NPAIR*CFG_W | Per-lane configuration words |
| cfg_out | output | 2*NPAIR*CFG_W | Registered copy of `cfg_in` |
| pwrdn | output | 2*NPAIR | Per-lane power-down, active high |
| pll_rst | output | NPAIR | Per-pair PLL reset, active high |
| lane_rst | output | 2*NPAIR | Per-lane reset, active high |
| pcs_rst_n | output | 1 | Coding-sublayer reset, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge, so that the past-value checks start from the defined reset state. They also assume that `start` and `pcs_start` change only between clock edges. They do not assume anything about when the requests arrive. The bench drives every input one nanosecond after a rising edge and samples outputs at the same offset. It deliberately pulses both requests while their own activity is running, so the ignore rules are exercised. The bench uses a small clock-frequency parameter so that the full release timeline stays short.

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq #(
  parameter int CLK_MHZ = 250,
  parameter int WAIT_US = 15,
  parameter int PCS_US  = 20,
  parameter int NPAIR   = 2,
  parameter int CFG_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       pcs_start,
  input  logic [2*NPAIR*CFG_W-1:0]   cfg_in,
  output logic [2*NPAIR*CFG_W-1:0]   cfg_out,
  output logic [2*NPAIR-1:0]         pwrdn,
  output logic [NPAIR-1:0]           pll_rst,
  output logic [2*NPAIR-1:0]         lane_rst,
  output logic                       pcs_rst_n,
  output logic                       busy,
  output logic                       done
);
  localparam int LANES    = 2 * NPAIR;
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int PCS_CYC  = CLK_MHZ * PCS_US;
  localparam int MAXC     = (WAIT_CYC > PCS_CYC) ? WAIT_CYC : PCS_CYC;
  localparam int TW       = $clog2(MAXC + 1);
  localparam int PW       = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int CW       = 2 * LANES + NPAIR;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} state_t;

  state_t          state;
  logic [TW-1:0]   tmr;
  logic [TW-1:0]   pcnt;
  logic [PW-1:0]   pair;
  logic [1:0]      kind;
  logic [PW:0]     lbase;
  logic            last_tick;
  logic [CW-1:0]   ctl;

  assign busy      = (state != S_IDLE);
  assign lbase     = {pair, 1'b0};
  assign last_tick = (tmr == TW'(WAIT_CYC - 1));
  assign ctl       = {lane_rst, pll_rst, pwrdn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmr      <= '0;
      pair     <= '0;
      kind     <= '0;
      pwrdn    <= '1;
      pll_rst  <= '1;
      lane_rst <= '1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_RUN;
            tmr      <= '0;
            pair     <= '0;
            kind     <= '0;
            pwrdn    <= '1;
            pll_rst  <= '1;
            lane_rst <= '1;
          end
        end
        S_RUN: begin
          if (last_tick) begin
            tmr <= '0;
            case (kind)
              2'd0:    pwrdn[lbase +: 2]    <= 2'b00;
              2'd1:    pll_rst[pair]        <= 1'b0;
              default: lane_rst[lbase +: 2] <= 2'b00;
            endcase
            if (kind == 2'd2) begin
              kind <= '0;
              if (pair == PW'(NPAIR - 1)) state <= S_TAIL;
              else                        pair  <= pair + 1'b1;
            end else begin
              kind <= kind + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcs_rst_n <= 1'b1;
      pcnt      <= '0;
    end else if (pcs_rst_n) begin
      if (pcs_start) begin
        pcs_rst_n <= 1'b0;
        pcnt      <= '0;
      end
    end else if (pcnt == TW'(PCS_CYC - 1)) begin
      pcs_rst_n <= 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_out <= '0;
    else        cfg_out <= cfg_in;
  end

  logic [TW:0] chk_low;
  always_ff @(posedge clk) begin
    if (!rst_n)          chk_low <= '0;
    else if (!pcs_rst_n) chk_low <= chk_low + 1'b1;
    else                 chk_low <= '0;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(!rst_n) |-> (&ctl && pcs_rst_n && !busy && !done)); // R1
  AST_START_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && &ctl)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !$past(busy)) |=> $stable(ctl)); // R6
  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(ctl) & ~ctl) <= 2); // R4
  AST_NO_RESET_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((ctl & ~$past(ctl)) == '0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ctl == '0)); // R5
  AST_PCS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcs_rst_n) |-> (chk_low == (TW+1)'(PCS_CYC))); // R7
  AST_PCS_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    chk_low <= (TW+1)'(PCS_CYC)); // R8

  for (genvar p = 0; p < NPAIR; p++) begin : g_order
    AST_PLL_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_rst[p] |-> (pwrdn[2*p+1:2*p] == 2'b00)); // R4
    AST_LANE_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_rst[2*p+1:2*p] != 2'b11) |-> !pll_rst[p]); // R4
    if (p > 0) begin : g_prev
      AST_PAIR_AFTER_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn[2*p+1:2*p] != 2'b11) |-> (lane_rst[2*p-1:2*p-2] == 2'b00)); // R4
    end
  end
endmodule

// File: tb/sim_serdes_rst_seq.sv
`timescale 1ns/1ps
module sim_serdes_rst_seq;
  localparam int CLK_MHZ = 2;
  localparam int WAIT_US = 15;
  localparam int PCS_US  = 20;
  localparam int NPAIR   = 2;
  localparam int CFG_W   = 8;
  localparam int LANES   = 2 * NPAIR;
  localparam int W       = CLK_MHZ * WAIT_US;
  localparam int PC      = CLK_MHZ * PCS_US;
  localparam int CW      = 2 * LANES + NPAIR;
  localparam int DW      = LANES * CFG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pcs_start = 1'b0;
  logic [DW-1:0] cfg_in = '0;
  logic [DW-1:0] cfg_out;
  logic [LANES-1:0] pwrdn, lane_rst;
  logic [NPAIR-1:0] pll_rst;
  logic pcs_rst_n, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serdes_rst_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .PCS_US(PCS_US),
                   .NPAIR(NPAIR), .CFG_W(CFG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pcs_start(pcs_start),
    .cfg_in(cfg_in), .cfg_out(cfg_out), .pwrdn(pwrdn), .pll_rst(pll_rst),
    .lane_rst(lane_rst), .pcs_rst_n(pcs_rst_n), .busy(busy), .done(done));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctlv();
    return 32'({lane_rst, pll_rst, pwrdn});
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    step(3);
    check("R1 controls in reset", ctlv(), 32'((1 << CW) - 1));
    rst_n = 1'b1;
    step(1);
    check("R1 controls after reset", ctlv(), 32'((1 << CW) - 1));
    check("R1 pcs_rst_n", 32'(pcs_rst_n), 1);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
  endtask

  task automatic t_sequence(input bit inject);
    logic [LANES-1:0] e_pd, e_lr;
    logic [NPAIR-1:0] e_pll;
    e_pd = '1; e_lr = '1; e_pll = '1;
    start = 1'b1;
    step(1);
    start = 1'b0;
    check("R2 all asserted", ctlv(), 32'((1 << CW) - 1));
    check("R2 busy", 32'(busy), 1);
    for (int p = 0; p < NPAIR; p++) begin
      for (int k = 0; k < 3; k++) begin
        if (inject && p == 0 && k == 1) begin
          step(5);
          start = 1'b1;
          step(1);
          start = 1'b0;
          check("R6 start ignored", ctlv(), 32'({e_lr, e_pll, e_pd}));
          step(W - 7);
        end else begin
          step(W - 1);
        end
        check("R3 held until interval ends", ctlv(), 32'({e_lr, e_pll, e_pd}));
        cfg_in = DW'(32'h1234_5678 + p * 40 + k);
        step(1);
        if (k == 0)      e_pd[2*p +: 2] = 2'b00;
        else if (k == 1) e_pll[p] = 1'b0;
        else             e_lr[2*p +: 2] = 2'b00;
        check("R4 group released", ctlv(), 32'({e_lr, e_pll, e_pd}));
        check("R9 cfg during sequence", 32'(cfg_out), 32'(DW'(32'h1234_5678 + p * 40 + k)));
      end
    end
    check("R5 busy in tail", 32'(busy), 1);
    check("R5 no early done", 32'(done), 0);
    step(1);
    check("R5 busy falls", 32'(busy), 0);
    check("R5 done pulse", 32'(done), 1);
    step(1);
    check("R5 done one cycle", 32'(done), 0);
    check("R5 controls stay released", ctlv(), 0);
  endtask

  task automatic t_pcs();
    pcs_start = 1'b1;
    step(1);
    pcs_start = 1'b0;
    check("R7 pcs low", 32'(pcs_rst_n), 0);
    step(9);
    pcs_start = 1'b1;
    step(1);
    pcs_start = 1'b0;
    step(PC - 11);
    check("R8 still low at end of width", 32'(pcs_rst_n), 0);
    step(1);
    check("R7 pcs high after width", 32'(pcs_rst_n), 1);
    step(3);
    check("R8 no retrigger", 32'(pcs_rst_n), 1);
  endtask

  task automatic t_cfg();
    cfg_in = DW'(32'hA5C3_0F11);
    step(1);
    check("R9 cfg captured", 32'(cfg_out), 32'(DW'(32'hA5C3_0F11)));
    cfg_in = DW'(32'h0BAD_F00D);
    #1;
    check("R9 cfg registered", 32'(cfg_out), 32'(DW'(32'hA5C3_0F11)));
    step(1);
    check("R9 cfg follows", 32'(cfg_out), 32'(DW'(32'h0BAD_F00D)));
  endtask

  initial begin
    step(1);
    t_reset();
    t_cfg();
    t_sequence(1'b0);
    t_pcs();
    t_sequence(1'b1);
    step(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule